// File: doc/BRIEF.md
# Dual-Lane 8B/10B Transmit Encoder

This block turns a two-byte transmit word into two 10-bit 8B/10B code groups in one clock. It is meant to sit in front of a serializer that shifts out the least significant bit first. Each byte carries a control flag. A flagged byte that names one of the twelve legal control characters becomes that control code. A flagged byte that names any other value is reported as a per-lane error and is encoded as ordinary data. Running disparity passes from the low lane to the high lane within a word, and from the high lane to the low lane of the next word. Each lane's disparity after its code group is reported.

A runtime enable chooses the mode. With the enable high, the encoded word and its status appear two clock edges after the input. With the enable low, the raw data and flags reach the output after a single edge and no encoding is done. Each code group is bit-reversed against the usual printed letter order, so bit a sits at the least significant position. The byte from the low half of the data word fills the low half of the output, so all of its bits are sent before those of the other byte.

Top module: `tx_pair_enc`

## Requirements
- R1: While rst_ni is low, code_o, kerr_o and rd_o are all zero. rd_o bit value 0 means negative running disparity and 1 means positive, so disparity starts negative.
- R2: When enc_en_i is high on two consecutive input cycles, the word presented in the first of them appears on code_o after the second rising edge. Lane 0 (code_o[9:0]) encodes data_i[7:0] and lane 1 (code_o[19:10]) encodes data_i[15:8], using the standard 5b/6b and 3b/4b sub-block tables.
- R3: Within a lane, code bits a,b,c,d,e,i occupy bit positions 0 to 5 and f,g,h,j occupy positions 6 to 9.
- R4: Lane 1 is encoded with the disparity left by lane 0 of the same word. Lane 0 is encoded with the disparity left by lane 1 of the previous encoded word. rd_o[n] is the disparity after lane n, and it is updated together with code_o.
- R5: With k_i[n] set, the values K28.0 to K28.7 (low five bits 28, any upper three bits), 0xF7, 0xFB, 0xFD and 0xFE produce the control code and leave kerr_o[n] at 0.
- R6: With k_i[n] set on any other byte value, kerr_o[n] is 1 and the lane carries that byte's data code.
- R7: Data values x.7 use the alternate 3b/4b group when x is 17, 18 or 20 at negative disparity, or 11, 13 or 14 at positive disparity. Control x.7 values always use it. No run of identical bits in the serial stream is longer than five.
- R8: When enc_en_i is low, after the next rising edge each lane n of code_o holds {1'b0, k_i[n], data byte n}, kerr_o is 0 and rd_o is unchanged. A word waiting in the encode stage is then discarded.
- R9: When enc_en_i is high and was low on the previous input cycle, code_o, kerr_o and rd_o keep their values at the next edge.
- R10: Every encoded lane has four to six ones. The cumulative disparity of the encoded stream, taken at each lane boundary, is +1 or -1 and agrees with rd_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_en_i | input | 1 | 1: encode, 0: raw bypass |
| data_i | input | 16 | Byte 0 in [7:0], byte 1 in [15:8] |
| k_i | input | 2 | Control-character request per byte |
| code_o | output | 20 | Lane 0 in [9:0], lane 1 in [19:10], first serial bit at LSB |
| kerr_o | output | 2 | Invalid control request per lane |
| rd_o | output | 2 | Running disparity after each lane, 1 = positive |

## Verification
A sweep over all 256 byte values with the control flag both clear and set on lane 0 exercises every data code, every legal control code and every illegal control request. Lane 1 follows a different value sequence at the same time, so the disparity handed from lane to lane reaches each table entry at both polarities. A dedicated pass over the twelve legal control values on both lanes separates true control codes from error-flagged data. A long random stream, biased toward control characters and split by bypass bursts, separates the R8 discard and R9 hold behaviour from the normal pipeline. The same stream is used to check run length and cumulative disparity against the encoded output.

// File: rtl/tx_pair_enc_pkg.sv
package tx_pair_enc_pkg;

  localparam int LANE_DW = 8;
  localparam int LANE_CW = 10;

  // 5b/6b group at negative disparity, written abcdei with a at the MSB
  function automatic logic [5:0] sb6_neg(input logic [4:0] x);
    logic [5:0] r;
    case (x)
      5'd0:  r = 6'b100111;
      5'd1:  r = 6'b011101;
      5'd2:  r = 6'b101101;
      5'd3:  r = 6'b110001;
      5'd4:  r = 6'b110101;
      5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;
      5'd7:  r = 6'b111000;
      5'd8:  r = 6'b111001;
      5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;
      5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;
      5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;
      5'd15: r = 6'b010111;
      5'd16: r = 6'b011011;
      5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;
      5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;
      5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;
      5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;
      5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;
      5'd27: r = 6'b110110;
      5'd28: r = 6'b001110;
      5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;
      default: r = 6'b101011;
    endcase
    return r;
  endfunction

  // 3b/4b data group at negative disparity, fghj with f at the MSB
  function automatic logic [3:0] sb4_data_neg(input logic [2:0] y, input logic alt7);
    logic [3:0] r;
    case (y)
      3'd0: r = 4'b1011;
      3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;
      3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;
      3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;
      default: r = alt7 ? 4'b0111 : 4'b1110;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] sb4_ctrl_neg(input logic [2:0] y);
    logic [3:0] r;
    case (y)
      3'd0: r = 4'b1011;
      3'd1: r = 4'b0110;
      3'd2: r = 4'b1010;
      3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;
      3'd5: r = 4'b0101;
      3'd6: r = 4'b1001;
      default: r = 4'b0111;
    endcase
    return r;
  endfunction

  function automatic logic ctrl_legal(input logic [7:0] b);
    return (b[4:0] == 5'd28) || (b == 8'hF7) || (b == 8'hFB) ||
           (b == 8'hFD) || (b == 8'hFE);
  endfunction

  function automatic logic [5:0] flip6(input logic [5:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v[5-i];
    return r;
  endfunction

  function automatic logic [3:0] flip4(input logic [3:0] v);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = v[3-i];
    return r;
  endfunction

endpackage

// File: rtl/tx_pair_enc_lane.sv
module tx_pair_enc_lane
  import tx_pair_enc_pkg::*;
(
  input  logic [LANE_DW-1:0] byte_i,
  input  logic               k_i,
  input  logic               rd_i,
  output logic [LANE_CW-1:0] code_o,
  output logic               rd_o,
  output logic               kerr_o
);

  logic [4:0] x;
  logic [2:0] y;
  logic       use_k, rd_mid, alt7, inv6, inv4, unb6, unb4;
  logic [5:0] c6n, c6;
  logic [3:0] c4n, c4;

  assign x = byte_i[4:0];
  assign y = byte_i[7:5];

  always_comb begin
    use_k  = k_i && ctrl_legal(byte_i);
    kerr_o = k_i && !ctrl_legal(byte_i);
    c6n    = (use_k && x == 5'd28) ? 6'b001111 : sb6_neg(x);
    unb6   = ($countones(c6n) != 3);
    inv6   = rd_i && (unb6 || c6n == 6'b111000);
    c6     = inv6 ? ~c6n : c6n;
    rd_mid = rd_i ^ unb6;
    // alternate x.7 avoids a run of five across the sub-block edge
    alt7   = (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
             ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14));
    c4n    = use_k ? sb4_ctrl_neg(y) : sb4_data_neg(y, alt7);
    unb4   = ($countones(c4n) != 2);
    inv4   = rd_mid && (use_k || unb4 || c4n == 4'b1100);
    c4     = inv4 ? ~c4n : c4n;
    rd_o   = rd_mid ^ unb4;
    code_o = {flip4(c4), flip6(c6)};
  end

endmodule

// File: rtl/tx_pair_enc_raw.sv
module tx_pair_enc_raw
  import tx_pair_enc_pkg::*;
#(
  parameter int N_LANES = 2
) (
  input  logic [LANE_DW*N_LANES-1:0] data_i,
  input  logic [N_LANES-1:0]         k_i,
  output logic [LANE_CW*N_LANES-1:0] raw_o
);

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign raw_o[LANE_CW*g +: LANE_CW] = {1'b0, k_i[g], data_i[LANE_DW*g +: LANE_DW]};
  end

endmodule

// File: rtl/tx_pair_enc.sv
module tx_pair_enc
  import tx_pair_enc_pkg::*;
#(
  parameter  int N_LANES = 2,
  localparam int DATA_W  = LANE_DW * N_LANES,
  localparam int CODE_W  = LANE_CW * N_LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [N_LANES-1:0] k_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N_LANES-1:0] kerr_o,
  output logic [N_LANES-1:0] rd_o
);

  logic [DATA_W-1:0]  s1_data_q;
  logic [N_LANES-1:0] s1_k_q;
  logic               s1_en_q;
  logic [CODE_W-1:0]  enc_code, raw_code, code_q;
  logic [N_LANES-1:0] enc_kerr, enc_rd, kerr_q, rd_q;
  logic [N_LANES:0]   rd_chain;

  assign rd_chain[0] = rd_q[N_LANES-1];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    tx_pair_enc_lane u_lane (
      .byte_i (s1_data_q[LANE_DW*g +: LANE_DW]),
      .k_i    (s1_k_q[g]),
      .rd_i   (rd_chain[g]),
      .code_o (enc_code[LANE_CW*g +: LANE_CW]),
      .rd_o   (rd_chain[g+1]),
      .kerr_o (enc_kerr[g])
    );
    assign enc_rd[g] = rd_chain[g+1];
  end

  tx_pair_enc_raw #(.N_LANES(N_LANES)) u_raw (
    .data_i (data_i),
    .k_i    (k_i),
    .raw_o  (raw_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_data_q <= '0;
      s1_k_q    <= '0;
      s1_en_q   <= 1'b0;
      code_q    <= '0;
      kerr_q    <= '0;
      rd_q      <= '0;
    end else begin
      s1_data_q <= data_i;
      s1_k_q    <= k_i;
      s1_en_q   <= enc_en_i;
      if (!enc_en_i) begin
        code_q <= raw_code;
        kerr_q <= '0;
      end else if (s1_en_q) begin
        code_q <= enc_code;
        kerr_q <= enc_kerr;
        rd_q   <= enc_rd;
      end
    end
  end

  assign code_o = code_q;
  assign kerr_o = kerr_q;
  assign rd_o   = rd_q;

endmodule

// File: rtl/tx_pair_enc_chk.sv
module tx_pair_enc_chk #(
  parameter int N_LANES = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   enc_en_i,
  input logic                   s1_en_i,
  input logic [10*N_LANES-1:0]  code_i,
  input logic [N_LANES-1:0]     kerr_i,
  input logic [N_LANES-1:0]     rd_i
);

  assert_bypass_kerr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_en_i |=> (kerr_i == '0));

  assert_bypass_rd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_en_i |=> $stable(rd_i));

  assert_first_cycle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_en_i && !s1_en_i) |=> ($stable(code_i) && $stable(rd_i) && $stable(kerr_i)));

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assert_lane_weight_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enc_en_i && s1_en_i) |=>
        ($countones(code_i[10*g +: 10]) >= 4 && $countones(code_i[10*g +: 10]) <= 6));

    if (g == 0) begin : g_first
      assert_rd_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enc_en_i && s1_en_i) |=>
          (rd_i[0] == ($past(rd_i[N_LANES-1]) ^ ($countones(code_i[9:0]) != 5))));
    end else begin : g_next
      assert_rd_chain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enc_en_i && s1_en_i) |=>
          (rd_i[g] == (rd_i[g-1] ^ ($countones(code_i[10*g +: 10]) != 5))));
    end
  end

endmodule

bind tx_pair_enc tx_pair_enc_chk #(.N_LANES(N_LANES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enc_en_i (enc_en_i),
  .s1_en_i  (s1_en_q),
  .code_i   (code_o),
  .kerr_i   (kerr_o),
  .rd_i     (rd_o)
);

// File: tb/tx_pair_enc_test.sv
module tx_pair_enc_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enc_en_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [1:0]  k_i = '0;
  logic [19:0] code_o;
  logic [1:0]  kerr_o, rd_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] prev_d = '0;
  logic [1:0]  prev_k = '0;
  logic        prev_en = 1'b0;
  logic        mrd = 1'b0;
  logic [19:0] exp_code = '0;
  logic [1:0]  exp_kerr = '0, exp_rd = '0;
  int          dsum = -1;
  int          run_len = 0;
  logic        last_bit = 1'b0;

  always #10 clk = ~clk;

  tx_pair_enc uut (
    .clk_i(clk), .rst_ni(rst_ni), .enc_en_i(enc_en_i),
    .data_i(data_i), .k_i(k_i), .code_o(code_o), .kerr_o(kerr_o), .rd_o(rd_o)
  );

  function automatic logic [5:0] m6(input logic [4:0] x, input logic rd);
    logic [5:0] r;
    case (x)
      5'd0:  r = rd ? 6'b011000 : 6'b100111;
      5'd1:  r = rd ? 6'b100010 : 6'b011101;
      5'd2:  r = rd ? 6'b010010 : 6'b101101;
      5'd3:  r = 6'b110001;
      5'd4:  r = rd ? 6'b001010 : 6'b110101;
      5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;
      5'd7:  r = rd ? 6'b000111 : 6'b111000;
      5'd8:  r = rd ? 6'b000110 : 6'b111001;
      5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;
      5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;
      5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;
      5'd15: r = rd ? 6'b101000 : 6'b010111;
      5'd16: r = rd ? 6'b100100 : 6'b011011;
      5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;
      5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;
      5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;
      5'd23: r = rd ? 6'b000101 : 6'b111010;
      5'd24: r = rd ? 6'b001100 : 6'b110011;
      5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;
      5'd27: r = rd ? 6'b001001 : 6'b110110;
      5'd28: r = 6'b001110;
      5'd29: r = rd ? 6'b010001 : 6'b101110;
      5'd30: r = rd ? 6'b100001 : 6'b011110;
      default: r = rd ? 6'b010100 : 6'b101011;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] m4d(input logic [2:0] y, input logic [4:0] x, input logic rd);
    logic [3:0] r;
    logic alt;
    alt = rd ? (x == 11 || x == 13 || x == 14) : (x == 17 || x == 18 || x == 20);
    case (y)
      3'd0: r = rd ? 4'b0100 : 4'b1011;
      3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;
      3'd3: r = rd ? 4'b0011 : 4'b1100;
      3'd4: r = rd ? 4'b0010 : 4'b1101;
      3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;
      default: r = alt ? (rd ? 4'b1000 : 4'b0111) : (rd ? 4'b0001 : 4'b1110);
    endcase
    return r;
  endfunction

  function automatic logic [3:0] m4k(input logic [2:0] y, input logic rd);
    logic [3:0] r;
    case (y)
      3'd0: r = rd ? 4'b0100 : 4'b1011;
      3'd1: r = rd ? 4'b1001 : 4'b0110;
      3'd2: r = rd ? 4'b0101 : 4'b1010;
      3'd3: r = rd ? 4'b0011 : 4'b1100;
      3'd4: r = rd ? 4'b0010 : 4'b1101;
      3'd5: r = rd ? 4'b1010 : 4'b0101;
      3'd6: r = rd ? 4'b0110 : 4'b1001;
      default: r = rd ? 4'b1000 : 4'b0111;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] kval(input int i);
    logic [7:0] r;
    if (i < 8) r = {i[2:0], 5'd28};
    else case (i)
      8: r = 8'hF7;
      9: r = 8'hFB;
      10: r = 8'hFD;
      default: r = 8'hFE;
    endcase
    return r;
  endfunction

  task automatic enc_model(input logic [7:0] b, input logic k, inout logic rd,
                           output logic [9:0] code, output logic kerr);
    logic legal, rd6;
    logic [5:0] c6;
    logic [3:0] c4;
    int o6, o;
    legal = (b[4:0] == 5'd28) ||
            (b[7:5] == 3'd7 && (b[4:0] == 23 || b[4:0] == 27 || b[4:0] == 29 || b[4:0] == 30));
    kerr = k && !legal;
    if (k && legal && b[4:0] == 5'd28) c6 = rd ? 6'b110000 : 6'b001111;
    else c6 = m6(b[4:0], rd);
    o6 = $countones(c6);
    rd6 = (o6 > 3) ? 1'b1 : (o6 < 3) ? 1'b0 : rd;
    c4 = (k && legal) ? m4k(b[7:5], rd6) : m4d(b[7:5], b[4:0], rd6);
    for (int i = 0; i < 6; i++) code[i] = c6[5-i];
    for (int j = 0; j < 4; j++) code[6+j] = c4[3-j];
    o = $countones(code);
    if (o > 5) rd = 1'b1;
    else if (o < 5) rd = 1'b0;
  endtask

  task automatic chk(input logic ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic stream_check();
    logic run_bad = 1'b0;
    for (int l = 0; l < 2; l++) begin
      int ones = $countones(code_o[10*l +: 10]);
      chk(ones >= 4 && ones <= 6, "R10 lane weight", 20'(ones), 20'd5);
      dsum += 2 * ones - 10;
      chk((dsum == 1 || dsum == -1) && (rd_o[l] == (dsum > 0)), "R10 stream disparity",
          20'(rd_o[l]), 20'(dsum > 0));
    end
    for (int b = 0; b < 20; b++) begin
      if (run_len > 0 && code_o[b] == last_bit) run_len++;
      else run_len = 1;
      last_bit = code_o[b];
      if (run_len > 5) run_bad = 1'b1;
    end
    chk(!run_bad, "R7 run length", code_o, 20'd0);
  endtask

  task automatic step(input logic [15:0] d, input logic [1:0] k, input logic en);
    logic [9:0] c0, c1;
    logic e0, e1;
    data_i = d; k_i = k; enc_en_i = en;
    @(posedge clk);
    @(negedge clk);
    if (!en) begin
      exp_code = {1'b0, k[1], d[15:8], 1'b0, k[0], d[7:0]};
      exp_kerr = 2'b00;
      run_len = 0;
      chk(code_o == exp_code, "R8 bypass code", code_o, exp_code);
      chk(kerr_o == exp_kerr, "R8 bypass kerr", 20'(kerr_o), 20'(exp_kerr));
      chk(rd_o == exp_rd, "R8 bypass rd hold", 20'(rd_o), 20'(exp_rd));
    end else if (prev_en) begin
      enc_model(prev_d[7:0], prev_k[0], mrd, c0, e0);
      exp_rd[0] = mrd;
      enc_model(prev_d[15:8], prev_k[1], mrd, c1, e1);
      exp_rd[1] = mrd;
      exp_code = {c1, c0};
      exp_kerr = {e1, e0};
      chk(code_o == exp_code, "R2/R3/R5/R7 code", code_o, exp_code);
      chk(kerr_o == exp_kerr, "R5/R6 kerr", 20'(kerr_o), 20'(exp_kerr));
      chk(rd_o == exp_rd, "R4 disparity", 20'(rd_o), 20'(exp_rd));
      stream_check();
    end else begin
      run_len = 0;
      chk(code_o == exp_code, "R9 hold code", code_o, exp_code);
      chk(kerr_o == exp_kerr && rd_o == exp_rd, "R9 hold status",
          20'({kerr_o, rd_o}), 20'({exp_kerr, exp_rd}));
    end
    prev_d = d; prev_k = k; prev_en = en;
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL R2 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(code_o == '0 && kerr_o == '0 && rd_o == '0, "R1 reset state",
        code_o ^ 20'({kerr_o, rd_o}), 20'd0);
    rst_ni = 1'b1;

    // R2 R3 R5 R6: every byte with flag clear and set on lane 0, varied lane 1
    for (int v = 0; v < 1024; v++) begin
      logic [7:0] b1 = 8'(v * 37 + 11);
      step({b1, v[7:0]}, {v[9] ^ v[0], v[8]}, 1'b1);
    end

    // R5: legal control values on both lanes
    for (int i = 0; i < 12; i++) step({kval(11 - i), kval(i)}, 2'b11, 1'b1);
    for (int i = 0; i < 12; i++) step({8'h4A, kval(i)}, 2'b01, 1'b1);
    step(16'h0000, 2'b00, 1'b1);

    // R8 then R9: discard of pending word and hold on re-entry
    for (int i = 0; i < 300; i++) step(16'($urandom()), 2'($urandom()), 1'b0);
    step(16'hBCBC, 2'b11, 1'b1);
    step(16'h1C1C, 2'b11, 1'b1);

    // R4 R7 R10: random stream biased to control bytes, with bypass bursts
    for (int n = 0; n < 20000; n++) begin
      logic [15:0] d = 16'($urandom());
      logic [1:0]  k = 2'b00;
      logic        en = ($urandom() % 64) != 0;
      for (int l = 0; l < 2; l++) begin
        if ($urandom() % 4 == 0) begin
          k[l] = 1'b1;
          if ($urandom() % 2 == 0) d[8*l +: 8] = kval(int'($urandom() % 12));
        end
      end
      step(d, k, en);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule